// File: doc/BRIEF.md
# Streamed Block-Read Command Engine

This block serves block-read requests that reach it as 32-bit words over a ready/valid input channel, the kind of channel a debug host uses to feed a target. The host first writes a command word. The upper half of that word holds a word count and the lower half holds an opcode. The host then writes a byte address. The engine reads that many consecutive 32-bit words from a synchronous memory port. It starts at the given address and adds four to the address after every word. Each word goes back to the host on a ready/valid output channel.

The engine keeps one memory read in flight at most. It issues the next read only after the host has taken the current word. A stalled host therefore never loses data, and the memory is never asked for more than the output can hold. If a command carries an opcode other than the configured read opcode, the engine discards that word and keeps waiting for a command. If the address word is misaligned, lies outside the memory or follows a zero count, the engine discards the request and reports it with a one-cycle error pulse.

Top module: `rdcmd_engine`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `out_valid`, `mem_req` and `err` are 0 and `in_ready` is 1.
- R2: A command word is taken when `in_valid` and `in_ready` are both high. Bits 31:16 give the word count and bits 15:0 give the opcode. When the opcode equals `READ_OP` (default 0x0000), `busy` rises on the next cycle and `in_ready` stays 1 while the engine waits for the address word.
- R3: A command word whose bits 15:0 differ from `READ_OP` is discarded. `busy` stays 0, no memory read is issued, and the next command word is handled normally.
- R4: After a valid address word A and count N, the output carries exactly N words. Word i (starting at 0) is the memory content at byte address A + 4*i. The words come in increasing address order, and each one appears on the cycle after its `mem_req`.
- R5: Each `mem_req` lasts one cycle. No `mem_req` is raised while `out_valid` is high. Exactly N reads are issued per accepted request.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value, even if the memory output changes.
- R7: An address word with bit 1 or bit 0 set discards the request. `err` is 1 for exactly one cycle, on the cycle after that word is taken. No memory read is issued and `busy` is 0 from that cycle on.
- R8: An address word that follows a command with count 0 is handled as in R7.
- R9: An address word with any bit at or above position `AW` set is handled as in R7.
- R10: `busy` is 1 in every state except idle. After the last word is taken there is one cycle with `busy` 1 and `out_valid` 0, and `busy` is 0 on the cycle after that.
- R11: `in_ready` is 1 only while the engine waits for a command or an address. It is 0 whenever `out_valid` or `mem_req` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host offers a word |
| in_ready | output | 1 | Engine takes the offered word |
| in_data | input | 32 | Command or address word |
| out_valid | output | 1 | A read word is on `out_data` |
| out_ready | input | 1 | Host takes the read word |
| out_data | output | 32 | Read word |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | AW | Byte address of the read |
| mem_rdata | input | 32 | Memory data, valid on the cycle after `mem_req` |
| busy | output | 1 | Engine is not idle |
| err | output | 1 | One-cycle pulse when a request is rejected |

## Verification
The assertions assume that the memory answers on the cycle after a strobe. They also assume that the host keeps `in_data` steady while `in_valid` waits for `in_ready`. The memory model in the bench delivers the word one cycle after `mem_req` and then inverts its output every cycle, so any data the engine did not capture gets corrupted in plain view. The host driver changes `in_valid`, `in_data` and `out_ready` only just after a rising edge and holds each word until the handshake completes. In the stalled runs `out_ready` follows a pseudo-random pattern, so the output holding path gets exercised.

// File: rtl/rdcmd_pkg.sv
package rdcmd_pkg;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 16;
    localparam int OP_W   = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET_ADDR,
        ST_READ_MEM,
        ST_SEND_WORD,
        ST_DONE
    } rd_state_e;

    typedef struct packed {
        rd_state_e state;
        logic      err;
    } ctl_regs_t;
endpackage

// File: rtl/rdcmd_cmd_check.sv
module rdcmd_cmd_check
    import rdcmd_pkg::*;
#(
    parameter int             AW      = 16,
    parameter logic [OP_W-1:0] READ_OP = '0
) (
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  cnt_held,
    output logic              op_match,
    output logic [CNT_W-1:0]  cnt_field,
    output logic              addr_ok
);
    logic hi_ok;

    generate
        if (AW < WORD_W) begin : g_hi
            assign hi_ok = (word[WORD_W-1:AW] == '0);
        end else begin : g_full
            assign hi_ok = 1'b1;
        end
    endgenerate

    assign op_match  = (word[OP_W-1:0] == READ_OP);
    assign cnt_field = word[WORD_W-1:WORD_W-CNT_W];
    assign addr_ok   = hi_ok && (word[1:0] == 2'b00) && (cnt_held != '0);
endmodule

// File: rtl/rdcmd_walker.sv
module rdcmd_walker
    import rdcmd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_cnt,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             load_addr,
    input  logic [AW-1:0]    addr_in,
    input  logic             step,
    output logic [AW-1:0]    addr,
    output logic [CNT_W-1:0] left,
    output logic             last
);
    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [CNT_W-1:0] left;
    } walk_t;

    walk_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (load_cnt) begin
            w_d.left = cnt_in;
        end
        if (load_addr) begin
            w_d.addr = addr_in;
        end
        if (step) begin
            w_d.addr = w_q.addr + AW'(4);
            w_d.left = w_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign addr = w_q.addr;
    assign left = w_q.left;
    assign last = (w_q.left == CNT_W'(1));

    p_step_adds_four_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load_addr |=> addr == $past(addr) + AW'(4));
endmodule

// File: rtl/rdcmd_hold.sv
module rdcmd_hold
    import rdcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [WORD_W-1:0] rdata_in,
    output logic [WORD_W-1:0] data_out
);
    typedef struct packed {
        logic              fresh;
        logic [WORD_W-1:0] data;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d       = h_q;
        h_d.fresh = req;
        if (h_q.fresh) begin
            h_d.data = rdata_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign data_out = h_q.fresh ? rdata_in : h_q.data;

    p_hold_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !h_q.fresh && !req |=> data_out == $past(data_out));
endmodule

// File: rtl/rdcmd_engine.sv
module rdcmd_engine
    import rdcmd_pkg::*;
#(
    parameter int              AW      = 16,
    parameter logic [OP_W-1:0] READ_OP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              err
);
    ctl_regs_t r_d, r_q;

    logic             op_match, addr_ok, last;
    logic             load_cnt, load_addr, step;
    logic [CNT_W-1:0] cnt_field, left;

    rdcmd_cmd_check #(.AW(AW), .READ_OP(READ_OP)) u_check (
        .word     (in_data),
        .cnt_held (left),
        .op_match (op_match),
        .cnt_field(cnt_field),
        .addr_ok  (addr_ok)
    );

    rdcmd_walker #(.AW(AW)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_cnt (load_cnt),
        .cnt_in   (cnt_field),
        .load_addr(load_addr),
        .addr_in  (in_data[AW-1:0]),
        .step     (step),
        .addr     (mem_addr),
        .left     (left),
        .last     (last)
    );

    rdcmd_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (mem_req),
        .rdata_in(mem_rdata),
        .data_out(out_data)
    );

    always_comb begin
        r_d       = r_q;
        r_d.err   = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        mem_req   = 1'b0;
        load_cnt  = 1'b0;
        load_addr = 1'b0;
        step      = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid && op_match) begin
                    load_cnt  = 1'b1;
                    r_d.state = ST_GET_ADDR;
                end
            end
            ST_GET_ADDR: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (addr_ok) begin
                        load_addr = 1'b1;
                        r_d.state = ST_READ_MEM;
                    end else begin
                        r_d.err   = 1'b1;
                        r_d.state = ST_IDLE;
                    end
                end
            end
            ST_READ_MEM: begin
                mem_req   = 1'b1;
                r_d.state = ST_SEND_WORD;
            end
            ST_SEND_WORD: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    step      = 1'b1;
                    r_d.state = last ? ST_DONE : ST_READ_MEM;
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.state != ST_IDLE);
    assign err  = r_q.err;

    p_word_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> out_valid);
    p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    p_stall_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    p_err_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(in_valid && in_ready) && !busy && !mem_req);
    p_tail_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && last |=> busy && !out_valid);
    p_ready_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid && !mem_req);
endmodule

// File: tb/rdcmd_engine_tb.sv
module rdcmd_engine_tb;
    localparam int AW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        mem_req;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        busy;
    logic        err;

    int total = 0;
    int bad = 0;
    int req_cnt = 0;
    int err_cnt = 0;
    int overlap = 0;
    int rdy_bad = 0;
    int extra = 0;
    int done_ph = 0;
    bit stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] exp_q[$];

    always #4 clk = ~clk;

    rdcmd_engine #(.AW(AW), .READ_OP(16'h0000)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .err(err)
    );

    function automatic logic [31:0] memf(logic [15:0] a);
        return {a ^ 16'hA5C3, a};
    endfunction

    always @(posedge clk) begin
        if (mem_req) mem_rdata <= memf(mem_addr);
        else         mem_rdata <= ~mem_rdata;
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = stall_mode ? lfsr[0] : 1'b1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) req_cnt++;
            if (mem_req && out_valid) overlap++;
            if (err) err_cnt++;
            if ((out_valid || mem_req) && in_ready) rdy_bad++;
            if (done_ph == 1) begin
                chk(busy && !out_valid, "R10 tail cycle busy/out_valid",
                    {30'd0, busy, out_valid}, 32'd2);
                done_ph = 2;
            end else if (done_ph == 2) begin
                chk(!busy, "R10 idle after tail", {31'd0, busy}, 32'd0);
                done_ph = 0;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    extra++;
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(out_data == e, "R4 read word", out_data, e);
                    if (exp_q.size() == 0) done_ph = 1;
                end
            end
        end
    end

    task automatic send(logic [31:0] w);
        bit taken;
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_data  = w;
        taken = 1'b0;
        while (!taken) begin
            @(negedge clk);
            taken = in_ready;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_data  = 32'hFFFF_FFFF;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        @(negedge clk);
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_read(logic [15:0] addr, int n);
        int r0;
        for (int i = 0; i < n; i++) exp_q.push_back(memf(addr + 16'(4 * i)));
        r0 = req_cnt;
        send({16'(n), 16'h0000});
        @(negedge clk);
        chk(busy && in_ready, "R2 busy and ready after command",
            {30'd0, busy, in_ready}, 32'd3);
        send({16'd0, addr});
        wait_idle();
        chk(exp_q.size() == 0, "R4 all words delivered", exp_q.size(), 0);
        chk(req_cnt - r0 == n, "R5 read count", req_cnt - r0, n);
        chk(extra == 0, "R4 no surplus words", extra, 0);
    endtask

    task automatic bad_req(logic [31:0] cmd, logic [31:0] addr, string tag);
        int r0, e0;
        r0 = req_cnt;
        e0 = err_cnt;
        send(cmd);
        send(addr);
        @(negedge clk);
        chk(!busy, {tag, " idle after reject"}, {31'd0, busy}, 0);
        repeat (3) @(negedge clk);
        chk(err_cnt - e0 == 1, {tag, " single err pulse"}, err_cnt - e0, 1);
        chk(req_cnt == r0, {tag, " no memory read"}, req_cnt - r0, 0);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        // R1 state during reset
        chk(!busy && !out_valid && !mem_req && !err && in_ready, "R1 reset outputs",
            {27'd0, busy, out_valid, mem_req, err, in_ready}, 32'd1);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !out_valid && !mem_req && !err && in_ready, "R1 after reset",
            {27'd0, busy, out_valid, mem_req, err, in_ready}, 32'd1);

        // R2 R4 R10 plain read
        run_read(16'h0100, 4);
        // R6 stalled output
        stall_mode = 1'b1;
        run_read(16'h2000, 7);
        run_read(16'h0040, 1);
        stall_mode = 1'b0;
        // R4 top of memory, single word
        run_read(16'hFFFC, 1);

        // R3 unknown opcode ignored
        r0 = req_cnt;
        send(32'h0003_0005);
        @(negedge clk);
        chk(!busy, "R3 busy after unknown opcode", {31'd0, busy}, 0);
        repeat (3) @(negedge clk);
        chk(req_cnt == r0, "R3 no read from unknown opcode", req_cnt - r0, 0);
        run_read(16'h0800, 3);

        bad_req(32'h0002_0000, 32'h0000_0102, "R7");
        bad_req(32'h0002_0000, 32'h0000_0101, "R7");
        bad_req(32'h0000_0000, 32'h0000_0200, "R8");
        bad_req(32'h0001_0000, 32'h0001_0000, "R9");

        // after rejects the engine still works
        stall_mode = 1'b1;
        run_read(16'h3000, 5);
        stall_mode = 1'b0;

        chk(overlap == 0, "R5 strobe while output valid", overlap, 0);
        chk(rdy_bad == 0, "R11 ready during streaming", rdy_bad, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule